// File: doc/BRIEF.md
# Serial Port Frame Sync Generator

This block is the framing section of a synchronous serial port. It runs one bit per serial clock. It tracks the bit position inside the current data word and the time slot inside the current frame. From that position it either drives a frame-sync pin or aligns itself to an incoming frame-sync edge. The data path that shifts words in and out follows `in_word`, `bit_idx` and `data_en` to know when to move a bit, and it takes `word_done` as the per-word completion pulse.

Framing can be switched off. When framing is on, the sync is generated internally or received from outside. Its polarity, width and timing are chosen with static inputs: the width is one clock or a whole word, and early timing places the pulse one clock before the first data bit while late timing places it on that bit. In multichannel operation a frame holds `frame_last+1` slots, up to `SLOTS` of them. A per-slot mask decides which slots carry data. A frame sync only marks slot 0.

Top module: `fsg_framer`

## Requirements
- R1: While `run` is low, `in_word`, `data_en` and `word_done` are 0 and `fs_out` sits at its idle level, which equals `fs_active_low`.
- R2: With `fs_enable` low, `fs_out` stays at the idle level, and words run back to back: the cycle in which `run` first reads high is a lead-in cycle with `in_word` 0, and bit 0 of the first word comes in the next cycle.
- R3: Internal sync with late timing and short width asserts `fs_out` for exactly one cycle, in the cycle of bit 0 of slot 0.
- R4: Early timing moves the internal pulse one cycle earlier. It then falls in the lead-in cycle or in the last bit of the preceding word.
- R5: Long width holds the internal pulse for WORD_BITS cycles, starting where the short pulse would start.
- R6: The asserted level of `fs_out`, and of `fs_in`, is 1 when `fs_active_low` is 0 and 0 when `fs_active_low` is 1.
- R7: `bit_idx` steps 0,1,…,WORD_BITS-1 on consecutive cycles. `word_done` is 1 exactly in the cycle of bit WORD_BITS-1 of a word with `data_en` high.
- R8: With `mc_en` high, slots count 0..`frame_last` and then wrap. `slot_mask` bit i enables slot i. `data_en` and `word_done` stay 0 in disabled slots, and the sync marks slot 0 only. With `mc_en` low every word is slot 0 and enabled.
- R9: External sync with late timing: a cycle in which `fs_in` is asserted after a deasserted cycle is itself bit 0 of slot 0. Before the first such edge `in_word` is 0. After the last bit of the frame, `in_word` returns to 0 until the next edge.
- R10: External sync with early timing: bit 0 of slot 0 comes in the cycle after the detected edge.
- R11: An external edge detected in the middle of a word restarts the word at bit 0.
- R12: With external sync selected, `fs_out` stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Port active |
| fs_enable | input | 1 | Framing on |
| fs_internal | input | 1 | 1: generate sync, 0: take sync from `fs_in` |
| fs_early | input | 1 | 1: sync one clock before bit 0, 0: sync with bit 0 |
| fs_long | input | 1 | 1: pulse lasts a whole word, 0: one clock |
| fs_active_low | input | 1 | Sync polarity |
| fs_in | input | 1 | External frame-sync pin |
| mc_en | input | 1 | Multichannel frame |
| frame_last | input | $clog2(SLOTS) | Index of the last slot in a frame |
| slot_mask | input | SLOTS | Per-slot enable |
| fs_out | output | 1 | Frame-sync pin drive |
| in_word | output | 1 | Current cycle belongs to a word |
| bit_idx | output | $clog2(WORD_BITS) | Bit position in the word |
| slot_idx | output | $clog2(SLOTS) | Slot position in the frame |
| data_en | output | 1 | Current bit belongs to an enabled slot |
| word_done | output | 1 | Last bit of an enabled word |

## Verification
The bench builds the block with WORD_BITS=4 and SLOTS=8. With these values a word lasts four cycles and a three-slot frame lasts twelve, so full words, the wrap back to slot 0 and the pulse width of every timing and width setting fit inside short observation windows. The mask can enable some slots and skip others, and the second frame's sync can be seen within a few cycles. The external-sync tests move the edge into the middle of a word and let a frame run out without a new edge, which exercises the restart and waiting behaviour.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    // How the position register moves on the next clock.
    typedef enum logic [1:0] {
        STEP_IDLE    = 2'd0,
        STEP_ADVANCE = 2'd1,
        STEP_ALIGN   = 2'd2
    } step_e;
endpackage

// File: rtl/fsg_sync_detect.sv
module fsg_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic active_low,
    input  logic arm,
    output logic edge_seen
);
    logic lvl_d, lvl_q;
    logic asserted;

    always_comb begin
        asserted  = pin ^ active_low;
        lvl_d     = asserted;
        edge_seen = arm & asserted & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/fsg_pulse_shape.sv
module fsg_pulse_shape #(
    parameter int BW  = 4,
    parameter int SIW = 7
) (
    input  logic           gen_on,
    input  logic           early,
    input  logic           long_pulse,
    input  logic           active_low,
    input  logic           cur_valid,
    input  logic [BW-1:0]  cur_bit,
    input  logic [SIW-1:0] cur_slot,
    input  logic           nxt_valid,
    input  logic [BW-1:0]  nxt_bit,
    input  logic [SIW-1:0] nxt_slot,
    output logic           fs_pin
);
    logic           p_valid;
    logic [BW-1:0]  p_bit;
    logic [SIW-1:0] p_slot;
    logic           hit;

    always_comb begin
        // early timing looks at the position one clock ahead
        p_valid = early ? nxt_valid : cur_valid;
        p_bit   = early ? nxt_bit   : cur_bit;
        p_slot  = early ? nxt_slot  : cur_slot;
        hit     = gen_on & p_valid & (p_slot == '0) & (long_pulse | (p_bit == '0));
        fs_pin  = hit ^ active_low;
    end
endmodule

// File: rtl/fsg_slot_gate.sv
module fsg_slot_gate #(
    parameter int WORD_BITS = 16,
    parameter int SLOTS     = 128,
    parameter int BW        = 4,
    parameter int SIW       = 7
) (
    input  logic             mc_en,
    input  logic [SLOTS-1:0] slot_mask,
    input  logic             valid,
    input  logic [BW-1:0]    bit_pos,
    input  logic [SIW-1:0]   slot_pos,
    output logic             data_en,
    output logic             word_done
);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

    always_comb begin
        data_en   = valid & (~mc_en | slot_mask[slot_pos]);
        word_done = data_en & (bit_pos == LAST_BIT);
    end
endmodule

// File: rtl/fsg_framer.sv
module fsg_framer #(
    parameter int WORD_BITS = 16,
    parameter int SLOTS     = 128,
    localparam int BW       = $clog2(WORD_BITS),
    localparam int SIW      = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fs_enable,
    input  logic             fs_internal,
    input  logic             fs_early,
    input  logic             fs_long,
    input  logic             fs_active_low,
    input  logic             fs_in,
    input  logic             mc_en,
    input  logic [SIW-1:0]   frame_last,
    input  logic [SLOTS-1:0] slot_mask,
    output logic             fs_out,
    output logic             in_word,
    output logic [BW-1:0]    bit_idx,
    output logic [SIW-1:0]   slot_idx,
    output logic             data_en,
    output logic             word_done
);
    import fsg_pkg::*;

    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

    typedef struct packed {
        logic           valid;
        logic [BW-1:0]  bitn;
        logic [SIW-1:0] slot;
    } pos_t;

    localparam pos_t POS_IDLE  = '{valid: 1'b0, bitn: '0, slot: '0};
    localparam pos_t POS_START = '{valid: 1'b1, bitn: '0, slot: '0};

    pos_t           st_d, st_q;
    pos_t           cur, adv;
    step_e          step;
    logic [SIW-1:0] last_slot;
    logic           ext_mode;
    logic           sync_edge;
    logic           frame_end;

    fsg_sync_detect u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (fs_in),
        .active_low (fs_active_low),
        .arm        (run & ext_mode),
        .edge_seen  (sync_edge)
    );

    always_comb begin
        ext_mode  = fs_enable & ~fs_internal;
        last_slot = mc_en ? frame_last : '0;

        // late external sync: the edge cycle is itself bit 0
        cur = st_q;
        if (sync_edge && !fs_early) cur = POS_START;

        // one-bit advance of the position
        if (!cur.valid) begin
            adv = POS_START;
        end else if (cur.bitn == LAST_BIT) begin
            adv.valid = 1'b1;
            adv.bitn  = '0;
            adv.slot  = (cur.slot >= last_slot) ? '0 : cur.slot + 1'b1;
        end else begin
            adv      = cur;
            adv.bitn = cur.bitn + 1'b1;
        end

        frame_end = cur.valid & (cur.bitn == LAST_BIT) & (cur.slot >= last_slot);

        if (!run)                           step = STEP_IDLE;
        else if (sync_edge && fs_early)     step = STEP_ALIGN;
        else if (ext_mode && !cur.valid)    step = STEP_IDLE;
        else if (ext_mode && frame_end)     step = STEP_IDLE;
        else                                step = STEP_ADVANCE;

        unique case (step)
            STEP_ALIGN:   st_d = POS_START;
            STEP_ADVANCE: st_d = adv;
            default:      st_d = POS_IDLE;
        endcase

        in_word  = run & cur.valid;
        bit_idx  = cur.bitn;
        slot_idx = cur.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= POS_IDLE;
        else        st_q <= st_d;
    end

    fsg_pulse_shape #(.BW(BW), .SIW(SIW)) u_pulse (
        .gen_on     (run & fs_enable & fs_internal),
        .early      (fs_early),
        .long_pulse (fs_long),
        .active_low (fs_active_low),
        .cur_valid  (cur.valid),
        .cur_bit    (cur.bitn),
        .cur_slot   (cur.slot),
        .nxt_valid  (adv.valid),
        .nxt_bit    (adv.bitn),
        .nxt_slot   (adv.slot),
        .fs_pin     (fs_out)
    );

    fsg_slot_gate #(.WORD_BITS(WORD_BITS), .SLOTS(SLOTS), .BW(BW), .SIW(SIW)) u_gate (
        .mc_en     (mc_en),
        .slot_mask (slot_mask),
        .valid     (in_word),
        .bit_pos   (cur.bitn),
        .slot_pos  (cur.slot),
        .data_en   (data_en),
        .word_done (word_done)
    );
endmodule

// File: rtl/fsg_framer_chk.sv
module fsg_framer_chk #(
    parameter int WORD_BITS = 16,
    parameter int SLOTS     = 128,
    localparam int BW       = $clog2(WORD_BITS),
    localparam int SIW      = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             fs_enable,
    input logic             fs_internal,
    input logic             fs_early,
    input logic             fs_long,
    input logic             fs_active_low,
    input logic             mc_en,
    input logic [SLOTS-1:0] slot_mask,
    input logic             fs_out,
    input logic             in_word,
    input logic [BW-1:0]    bit_idx,
    input logic [SIW-1:0]   slot_idx,
    input logic             data_en,
    input logic             word_done
);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!in_word && !data_en && !word_done && fs_out == fs_active_low));

    a_r2_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_enable |-> fs_out == fs_active_low);

    a_r12_ext_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_enable && !fs_internal) |-> fs_out == fs_active_low);

    a_r3_late_pulse_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fs_enable && fs_internal && !fs_early && !fs_long && fs_out != fs_active_low)
        |-> (in_word && bit_idx == '0 && slot_idx == '0));

    a_r7_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fs_internal && in_word && bit_idx != LAST_BIT)
        |=> (!run || !fs_internal || bit_idx == BW'($past(bit_idx) + 1'b1)));

    a_r7_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (data_en && bit_idx == LAST_BIT));

    a_r8_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> (in_word && (!mc_en || slot_mask[slot_idx])));
endmodule

bind fsg_framer fsg_framer_chk #(.WORD_BITS(WORD_BITS), .SLOTS(SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .fs_enable     (fs_enable),
    .fs_internal   (fs_internal),
    .fs_early      (fs_early),
    .fs_long       (fs_long),
    .fs_active_low (fs_active_low),
    .mc_en         (mc_en),
    .slot_mask     (slot_mask),
    .fs_out        (fs_out),
    .in_word       (in_word),
    .bit_idx       (bit_idx),
    .slot_idx      (slot_idx),
    .data_en       (data_en),
    .word_done     (word_done)
);

// File: tb/fsg_framer_test.sv
`timescale 1ns/100ps
module fsg_framer_test;
    localparam int WB  = 4;
    localparam int SL  = 8;
    localparam int BW  = $clog2(WB);
    localparam int SIW = $clog2(SL);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run = 1'b0;
    logic           fs_enable = 1'b0;
    logic           fs_internal = 1'b1;
    logic           fs_early = 1'b0;
    logic           fs_long = 1'b0;
    logic           fs_active_low = 1'b0;
    logic           fs_in = 1'b0;
    logic           mc_en = 1'b0;
    logic [SIW-1:0] frame_last = '0;
    logic [SL-1:0]  slot_mask = '0;
    logic           fs_out, in_word, data_en, word_done;
    logic [BW-1:0]  bit_idx;
    logic [SIW-1:0] slot_idx;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    fsg_framer #(.WORD_BITS(WB), .SLOTS(SL)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .fs_enable(fs_enable),
        .fs_internal(fs_internal), .fs_early(fs_early), .fs_long(fs_long),
        .fs_active_low(fs_active_low), .fs_in(fs_in), .mc_en(mc_en),
        .frame_last(frame_last), .slot_mask(slot_mask), .fs_out(fs_out),
        .in_word(in_word), .bit_idx(bit_idx), .slot_idx(slot_idx),
        .data_en(data_en), .word_done(word_done)
    );

    // internal-sync window table: en, early, long, low, first asserted cycle, asserted count
    typedef struct packed {
        logic       en;
        logic       early;
        logic       lng;
        logic       low;
        logic [7:0] first;
        logic [7:0] count;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{en: 1'b1, early: 1'b0, lng: 1'b0, low: 1'b0, first: 8'd1,   count: 8'd2}, // R3
        '{en: 1'b1, early: 1'b1, lng: 1'b0, low: 1'b0, first: 8'd0,   count: 8'd2}, // R4
        '{en: 1'b1, early: 1'b0, lng: 1'b1, low: 1'b0, first: 8'd1,   count: 8'd7}, // R5
        '{en: 1'b1, early: 1'b1, lng: 1'b1, low: 1'b0, first: 8'd0,   count: 8'd8}, // R5 with R4
        '{en: 1'b1, early: 1'b0, lng: 1'b0, low: 1'b1, first: 8'd1,   count: 8'd2}, // R6
        '{en: 1'b0, early: 1'b0, lng: 1'b0, low: 1'b0, first: 8'd255, count: 8'd0}  // R2
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic start_run();
        @(posedge clk); #1; run = 1'b0;
        @(posedge clk); #1; run = 1'b1;
        cyc = 0;
    endtask

    task automatic to(input int n);
        while (cyc < n) begin
            @(posedge clk); #1;
            cyc++;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // reset and idle state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 in_word idle", int'(in_word), 0);
        chk("R1 word_done idle", int'(word_done), 0);
        chk("R1 fs_out idle high-active", int'(fs_out), 0);
        fs_active_low = 1'b1;
        #1;
        chk("R1 fs_out idle low-active", int'(fs_out), 1);

        // table walk over internal sync settings
        for (int v = 0; v < 6; v++) begin
            int first;
            int cnt;
            fs_internal   = 1'b1;
            mc_en         = 1'b0;
            fs_enable     = VECS[v].en;
            fs_early      = VECS[v].early;
            fs_long       = VECS[v].lng;
            fs_active_low = VECS[v].low;
            start_run();
            first = 255;
            cnt   = 0;
            for (int k = 0; k < 8; k++) begin
                #1;
                if ((fs_out ^ fs_active_low) == 1'b1) begin
                    if (first == 255) first = k;
                    cnt++;
                end
                @(posedge clk); #1;
            end
            chk("R3/R4/R5/R6/R2 first pulse cycle", first, int'(VECS[v].first));
            chk("R3/R4/R5/R6/R2 pulse length", cnt, int'(VECS[v].count));
        end

        // R7 bit order and completion
        fs_enable = 1'b1; fs_internal = 1'b1; fs_early = 1'b0; fs_long = 1'b0;
        fs_active_low = 1'b0; mc_en = 1'b0;
        start_run();
        #1;
        chk("R7 lead-in not a word", int'(in_word), 0);
        to(3); #1;
        chk("R7 bit 2", int'(bit_idx), 2);
        chk("R7 no done mid word", int'(word_done), 0);
        to(4); #1;
        chk("R7 bit 3", int'(bit_idx), 3);
        chk("R7 done on last bit", int'(word_done), 1);
        to(5); #1;
        chk("R7 wrap to bit 0", int'(bit_idx), 0);

        // R2 words run without framing
        fs_enable = 1'b0;
        start_run();
        to(1); #1;
        chk("R2 first word starts", int'(in_word), 1);
        chk("R2 first bit", int'(bit_idx), 0);

        // R8 multichannel, slots 0 and 2 enabled of 3
        fs_enable = 1'b1; mc_en = 1'b1; frame_last = 3'd2; slot_mask = 8'b0000_0101;
        start_run();
        to(1); #1;
        chk("R8 sync at slot 0", int'(fs_out), 1);
        to(5); #1;
        chk("R8 no sync at slot 1", int'(fs_out), 0);
        chk("R8 slot 1 masked", int'(data_en), 0);
        to(8); #1;
        chk("R8 no done in masked slot", int'(word_done), 0);
        to(9); #1;
        chk("R8 slot 2 index", int'(slot_idx), 2);
        chk("R8 slot 2 enabled", int'(data_en), 1);
        to(13); #1;
        chk("R8 wrap slot index", int'(slot_idx), 0);
        chk("R8 sync at next frame", int'(fs_out), 1);

        // R9 R11 R12 external late sync, active low
        mc_en = 1'b0; frame_last = '0; slot_mask = '0;
        fs_internal = 1'b0; fs_early = 1'b0; fs_active_low = 1'b1; fs_in = 1'b1;
        start_run();
        to(2); #1;
        chk("R9 waits for sync", int'(in_word), 0);
        chk("R12 no drive in external mode", int'(fs_out), 1);
        to(3); fs_in = 1'b0; #1;
        chk("R9 edge cycle is a word", int'(in_word), 1);
        chk("R9 edge cycle is bit 0", int'(bit_idx), 0);
        to(4); fs_in = 1'b1; #1;
        chk("R9 bit 1 after edge", int'(bit_idx), 1);
        to(5); fs_in = 1'b0; #1;
        chk("R11 restart mid word", int'(bit_idx), 0);
        to(6); fs_in = 1'b1; #1;
        chk("R11 count resumes", int'(bit_idx), 1);
        to(8); #1;
        chk("R9 last bit", int'(bit_idx), 3);
        chk("R9 done on last bit", int'(word_done), 1);
        to(9); #1;
        chk("R9 back to waiting", int'(in_word), 0);

        // R10 external early sync, active high
        fs_early = 1'b1; fs_active_low = 1'b0; fs_in = 1'b0;
        start_run();
        to(2); fs_in = 1'b1; #1;
        chk("R10 edge cycle not a word", int'(in_word), 0);
        to(3); fs_in = 1'b0; #1;
        chk("R10 word follows edge", int'(in_word), 1);
        chk("R10 bit 0 after edge", int'(bit_idx), 0);

        run = 1'b0;
        @(posedge clk); #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule